// File: doc/BRIEF.md
# Decimal Digit Adder with Subtract-Ten Correction

This block adds two decimal digits, each held on a 4-bit input in the range 0 to 9. It returns the result as two decimal digits: a tens digit that is 0 or 1 and a units digit from 0 to 9. Both digits are 4 bits wide, so each one can drive a hexadecimal digit display without further decoding.

Internally, a ripple-carry adder forms the 5-bit binary sum of the operands. A threshold detector flags sums of ten or more. A second ripple adder subtracts ten from the low four bits of the sum by adding the inverse of ten with a carry-in of one. A per-bit 2-to-1 multiplexer, driven by the threshold flag, then chooses between the corrected and the uncorrected units value. If either operand is above 9, an invalid flag is raised.

A build-time parameter places a register stage on the outputs. In that stage the digits and the flag are captured on a rising clock edge whenever an input strobe is high.

Top module: `dec_digit_adder`

## Requirements
- R1: When both operands are 0..9, the outputs satisfy tens*10 + units == op_x + op_y, and units never exceeds 9.
- R2: The tens output is 4'b0001 exactly when op_x + op_y is 10 or more, and 4'b0000 otherwise.
- R3: At the correction threshold the digits are exact. A sum of 9 gives tens 0 and units 9, a sum of 10 gives tens 1 and units 0, a sum of 18 gives tens 1 and units 8, and 9 + 3 gives tens 1 and units 2.
- R4: The invalid output is 1 when op_x > 9 or op_y > 9, and 0 when both operands are 0..9.
- R5: With the register stage enabled (the default), a result is captured on the rising edge at which in_valid is 1 and appears on the outputs after that edge. out_valid equals the value in_valid had at the previous rising edge.
- R6: On a rising edge where in_valid is 0, tens, units and invalid keep their previous values, even if the operands change.
- R7: A synchronous active-high reset sets tens, units, invalid and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture the current operands' result |
| op_x | input | 4 | First decimal operand |
| op_y | input | 4 | Second decimal operand |
| out_valid | output | 1 | in_valid delayed by one cycle |
| tens | output | 4 | Tens digit, 0 or 1 |
| units | output | 4 | Units digit, 0..9 |
| invalid | output | 1 | Set when an operand exceeds 9 |

## Verification
The subtract-ten correction and the invalid flag can both be active in the same cycle. This happens when an out-of-range operand also pushes the binary sum past the threshold. The exhaustive sweep over all 256 operand codes provokes it, and the invalid flag is judged on every pair while the digits are judged only on legal pairs. Capture and hold can also meet in consecutive cycles: a strobed sum at the top of the range is followed by an unstrobed change of the operands, and the held digits must still show the earlier result.

// File: rtl/dsum_pkg.sv
package dsum_pkg;
  localparam int DIGIT_W   = 4;
  localparam int RADIX     = 10;
  localparam int MAX_DIGIT = RADIX - 1;

  typedef struct packed {
    logic [DIGIT_W-1:0] tens;
    logic [DIGIT_W-1:0] units;
    logic               invalid;
  } dsum_result_t;
endpackage

// File: rtl/dsum_ripple_adder.sv
module dsum_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      // full adder cell: sum is a three-input xor, carry is majority
      assign sum[i]     = a[i] ^ b[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] | b[i]));
    end
  endgenerate

  assign cout = carry[W];
endmodule

// File: rtl/dsum_ten_detect.sv
module dsum_ten_detect #(
  parameter int W = 4
) (
  input  logic [W:0] z,
  output logic       ge_ten
);
  // sums of sixteen or more, or 12..15 (bits 3,2), or 10..11 (bits 3,1)
  assign ge_ten = z[W] | (z[W-1] & z[W-2]) | (z[W-1] & z[W-3]);

  always_comb begin
    if (!$isunknown(z)) begin
      a_r2_threshold: assert (ge_ten == (int'(z) >= 10))
        else $error("threshold detector disagrees with sum %0d", z);
    end
  end
endmodule

// File: rtl/dsum_digit_mux.sv
module dsum_digit_mux #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_mux
      assign y[i] = (sel & d1[i]) | (~sel & d0[i]);
    end
  endgenerate
endmodule

// File: rtl/dec_digit_adder.sv
module dec_digit_adder
  import dsum_pkg::*;
#(
  parameter int DW      = DIGIT_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] op_x,
  input  logic [DW-1:0] op_y,
  output logic          out_valid,
  output logic [DW-1:0] tens,
  output logic [DW-1:0] units,
  output logic          invalid
);
  localparam logic [DW-1:0] TEN_C   = DW'(RADIX);
  localparam logic [DW-1:0] TEN_INV = ~TEN_C;
  localparam logic [DW-1:0] MAX_C   = DW'(MAX_DIGIT);

  logic [DW:0]   z;
  logic [DW-1:0] z_minus_ten;
  logic          sub_cout;
  logic          ge_ten;
  logic [DW-1:0] units_c;
  logic [DW-1:0] tens_c;
  logic          invalid_c;

  dsum_ripple_adder #(.W(DW)) u_sum (
    .a(op_x), .b(op_y), .cin(1'b0), .sum(z[DW-1:0]), .cout(z[DW])
  );

  dsum_ten_detect #(.W(DW)) u_det (
    .z(z), .ge_ten(ge_ten)
  );

  // two's-complement subtraction of ten on the low bits (modulo 2^DW)
  dsum_ripple_adder #(.W(DW)) u_sub (
    .a(z[DW-1:0]), .b(TEN_INV), .cin(1'b1), .sum(z_minus_ten), .cout(sub_cout)
  );

  dsum_digit_mux #(.W(DW)) u_mux (
    .sel(ge_ten), .d0(z[DW-1:0]), .d1(z_minus_ten), .y(units_c)
  );

  assign tens_c    = {{(DW-1){1'b0}}, ge_ten};
  assign invalid_c = (op_x > MAX_C) | (op_y > MAX_C);

  always_comb begin
    if (!$isunknown({op_x, op_y}) && !invalid_c) begin
      a_r1_digits_sum: assert ((int'(tens_c) * RADIX + int'(units_c)) == (int'(op_x) + int'(op_y)))
        else $error("digits do not rebuild operand sum");
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      dsum_result_t res_q;
      logic         vld_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          res_q <= '0;
          vld_q <= 1'b0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) begin
            res_q.tens    <= tens_c;
            res_q.units   <= units_c;
            res_q.invalid <= invalid_c;
          end
        end
      end

      assign tens      = res_q.tens;
      assign units     = res_q.units;
      assign invalid   = res_q.invalid;
      assign out_valid = vld_q;

      a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r5_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable({tens, units, invalid}));
      a_r1_units_range: assert property (@(posedge clk) disable iff (rst)
        !invalid |-> (units <= MAX_C));
      a_r2_tens_bit: assert property (@(posedge clk) disable iff (rst)
        tens <= 1);
      a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && tens == '0 && units == '0 && !invalid));
    end else begin : g_comb
      assign tens      = tens_c;
      assign units     = units_c;
      assign invalid   = invalid_c;
      assign out_valid = in_valid;
    end
  endgenerate
endmodule

// File: tb/dec_digit_adder_tb_top.sv
module dec_digit_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op_x = '0;
  logic [3:0] op_y = '0;
  logic       out_valid;
  logic [3:0] tens;
  logic [3:0] units;
  logic       invalid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_digit_adder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
    .out_valid(out_valid), .tens(tens), .units(units), .invalid(invalid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on falling edge, result captured on next rising edge, sampled on the falling edge after
  task automatic apply(input int x, input int y, input bit v);
    @(negedge clk);
    op_x = 4'(x);
    op_y = 4'(y);
    in_valid = v;
    @(negedge clk);
  endtask

  task automatic check_digits(input string req, input int x, input int y);
    check({req, " tens"},  int'(tens),  (x + y) / 10);
    check({req, " units"}, int'(units), (x + y) % 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 out_valid", int'(out_valid), 0);
    check("R7 tens", int'(tens), 0);
    check("R7 units", int'(units), 0);
    check("R7 invalid", int'(invalid), 0);
    rst = 1'b0;

    // R1 R2 R4 R5: exhaustive sweep of all operand codes
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply(x, y, 1'b1);
        check("R5 out_valid", int'(out_valid), 1);
        check("R4 invalid", int'(invalid), (x > 9 || y > 9) ? 1 : 0);
        if (x <= 9 && y <= 9) begin
          check_digits("R1", x, y);
          check("R2 tens flag", int'(tens), (x + y >= 10) ? 1 : 0);
        end
      end
    end

    // R3: threshold corners
    apply(4, 5, 1'b1); check_digits("R3 sum9", 4, 5);
    apply(3, 7, 1'b1); check_digits("R3 sum10", 3, 7);
    apply(9, 9, 1'b1); check_digits("R3 sum18", 9, 9);
    apply(9, 3, 1'b1); check_digits("R3 nine_plus_three", 9, 3);

    // R6: no strobe, operands change, outputs hold 9+3
    apply(0, 1, 1'b0);
    check("R5 out_valid idle", int'(out_valid), 0);
    check_digits("R6 hold", 9, 3);
    check("R6 invalid hold", int'(invalid), 0);
    apply(12, 1, 1'b0);
    check("R6 invalid held low", int'(invalid), 0);
    check_digits("R6 hold2", 9, 3);

    // R7: reset mid-run
    apply(8, 8, 1'b1);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R7 mid tens", int'(tens), 0);
    check("R7 mid units", int'(units), 0);
    check("R7 mid out_valid", int'(out_valid), 0);
    rst = 1'b0;
    apply(6, 6, 1'b1); check_digits("R1 after reset", 6, 6);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule